// File: doc/BRIEF.md
# Debug Trigger Match Unit with Chaining

This block holds a small bank of debug triggers for a processor core. Each trigger is configured through three data registers. Software reaches them through an index register that picks which trigger the data registers address. A match trigger compares one event reported by the pipeline against its programmed 32-bit value and its timing slot (before or after the access). The event can be an instruction fetch address, an instruction opcode, a load or store address, or load or store data. An instruction-count trigger instead counts retired instructions down to zero.

Triggers can be linked into chains, and a chain fires only when every member matched the same event. The pipeline receives combinational counts of the triggers that fired in the before and after slots, plus a request to enter debug mode. A match sets the trigger's local-hit flag whether or not its chain fires. A firing chain also sets the hit flag of every member. An optional restriction allows a link only from an even-numbered trigger to the odd-numbered one above it.

Top module: `dtrig_unit`

## Requirements
- R1: After reset the select register reads 0, every data register of every trigger reads 0, and tripBefore, tripAfter and enterDebug are 0 while no event or retirement is presented.
- R2: A write to address 0x7A0 updates the select register only when the written value is below NUM_TRIG; other values leave it unchanged. Addresses 0x7A1, 0x7A2 and 0x7A3 read and write data registers 1, 2 and 3 of the selected trigger. Any other address reads 0.
- R3: Data register 1 has these fields. Bits [31:28] hold the type: 2 is a match trigger, 3 is an instruction-count trigger, and anything else is inert. Bit 0 enables loads, bit 1 stores and bit 2 instruction fetch. Bit 19 selects address (0) or data/opcode (1). Bit 18 selects the timing, where 1 is after. A match trigger fires on an event whose kind is enabled, whose timing equals bit 18 and whose value equals data register 2 exactly. evKind is 0 load address, 1 store address, 2 load data, 3 store data, 4 fetch address and 5 opcode.
- R4: tripBefore and tripAfter are, in the same cycle as the event, the numbers of fired triggers whose timing bit is 0 and 1 respectively. A firing instruction-count trigger counts as after. Both counts are 0 when no event and no retirement is presented.
- R5: A matching trigger sets its local-hit bit (data register 1 bit 21) at the next clock edge, even when its chain does not fire.
- R6: Bit 11 of a match trigger links it to the next higher-numbered trigger, and the last trigger always ends a chain. A chain fires only when all its members match the same event. All members then fire and get their hit bit (bit 20) set.
- R7: When cfgEvenOddChain is 1, only links from an even-numbered trigger to the next odd one are honoured. The link bit of an odd-numbered trigger is then ignored.
- R8: Load-data matching requires cfgLoadDataEn=1 and opcode matching requires cfgOpcodeEn=1. With the input at 0, the event kind never matches.
- R9: A trigger takes part only when its privilege enable for privMode is set. Bit 6 enables machine (privMode 3), bit 4 supervisor (privMode 1) and bit 3 user (privMode 0).
- R10: On each cycle with retireValid=1, an active instruction-count trigger with a non-zero data register 2 decrements it. It does not decrement when the same cycle writes any of its data registers. The step from 1 to 0 fires it and sets bits 20 and 21.
- R11: enterDebug is 1 in the cycle a fired trigger has action field bits [15:12] equal to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| csrWrEn | input | 1 | Register write strobe |
| csrAddr | input | 12 | Register address |
| csrWrData | input | 32 | Register write data |
| csrRdData | output | 32 | Combinational read data for csrAddr |
| evValid | input | 1 | A match event is presented this cycle |
| evKind | input | 3 | Event kind (encoding in R3) |
| evValue | input | 32 | Address, data or opcode of the event |
| evTiming | input | 1 | 0 before, 1 after |
| privMode | input | 2 | Current privilege: 0 user, 1 supervisor, 3 machine |
| retireValid | input | 1 | One instruction retires this cycle |
| cfgLoadDataEn | input | 1 | Allows load-data matching |
| cfgOpcodeEn | input | 1 | Allows opcode matching |
| cfgEvenOddChain | input | 1 | Restricts links to even/odd pairs |
| tripBefore | output | $clog2(NUM_TRIG+1) | Number of before-timing triggers fired |
| tripAfter | output | $clog2(NUM_TRIG+1) | Number of after-timing triggers fired |
| enterDebug | output | 1 | A fired trigger requests debug mode |

## Verification
The bench builds the unit with NUM_TRIG=4. With four triggers, a chain of two, a trigger outside it, and an odd-numbered link that the even/odd restriction must drop can all exist in the same setup. Four triggers also let the last trigger serve as an instruction-count trigger while the lower three carry match setups. The random phase spreads the six event kinds, both timings and three privilege levels over four independent triggers whose values come from a small shared pool, so several triggers often fire together and both counts reach values above 1.

// File: rtl/dtrig_pkg.sv
package dtrig_pkg;
  localparam int MAX_TRIG = 8;
  localparam int XLEN = 32;

  localparam logic [11:0] ADDR_SEL = 12'h7A0;
  localparam logic [11:0] ADDR_D1  = 12'h7A1;
  localparam logic [11:0] ADDR_D2  = 12'h7A2;
  localparam logic [11:0] ADDR_D3  = 12'h7A3;

  localparam logic [3:0] TYPE_MATCH = 4'd2;
  localparam logic [3:0] TYPE_COUNT = 4'd3;
  localparam logic [3:0] ACT_DEBUG  = 4'd1;

  localparam int B_LOAD  = 0;
  localparam int B_STORE = 1;
  localparam int B_EXEC  = 2;
  localparam int B_UEN   = 3;
  localparam int B_SEN   = 4;
  localparam int B_MEN   = 6;
  localparam int B_LINK  = 11;
  localparam int B_AFTER = 18;
  localparam int B_DATA  = 19;
  localparam int B_HIT   = 20;
  localparam int B_LOCAL = 21;

  typedef enum logic [2:0] {
    EV_LD_ADDR = 3'd0,
    EV_ST_ADDR = 3'd1,
    EV_LD_DATA = 3'd2,
    EV_ST_DATA = 3'd3,
    EV_FETCH   = 3'd4,
    EV_OPCODE  = 3'd5
  } ev_kind_e;

  typedef struct packed {
    logic [MAX_TRIG-1:0] setLocal;
    logic [MAX_TRIG-1:0] setHit;
    logic [MAX_TRIG-1:0] decCount;
  } trig_strobe_t;
endpackage

// File: rtl/dtrig_regs.sv
module dtrig_regs
  import dtrig_pkg::*;
#(
  parameter int NUM_TRIG = 4
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  logic                               csrWrEn,
  input  logic [11:0]                        csrAddr,
  input  logic [XLEN-1:0]                    csrWrData,
  output logic [XLEN-1:0]                    csrRdData,
  input  trig_strobe_t                       strobe,
  output logic [NUM_TRIG-1:0][XLEN-1:0]      data1Q,
  output logic [NUM_TRIG-1:0][XLEN-1:0]      data2Q,
  output logic [NUM_TRIG-1:0]                wroteNow
);
  localparam int SEL_W = (NUM_TRIG > 1) ? $clog2(NUM_TRIG) : 1;

  logic [SEL_W-1:0] selQ;
  logic [NUM_TRIG-1:0][XLEN-1:0] data3Q;

  always_ff @(posedge clk) begin
    if (!rstN) selQ <= '0;
    else if (csrWrEn && csrAddr == ADDR_SEL && csrWrData < NUM_TRIG)
      selQ <= csrWrData[SEL_W-1:0];
  end

  for (genvar i = 0; i < NUM_TRIG; i++) begin : g_trig
    logic isSel, wr1, wr2, wr3;
    logic [XLEN-1:0] hwSet;
    assign isSel = (selQ == SEL_W'(i));
    assign wr1 = csrWrEn && isSel && csrAddr == ADDR_D1;
    assign wr2 = csrWrEn && isSel && csrAddr == ADDR_D2;
    assign wr3 = csrWrEn && isSel && csrAddr == ADDR_D3;
    assign wroteNow[i] = wr1 | wr2 | wr3;

    always_comb begin
      hwSet = '0;
      hwSet[B_HIT]   = strobe.setHit[i];
      hwSet[B_LOCAL] = strobe.setLocal[i];
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        data1Q[i] <= '0;
        data2Q[i] <= '0;
        data3Q[i] <= '0;
      end else begin
        if (wr1) data1Q[i] <= csrWrData;
        else     data1Q[i] <= data1Q[i] | hwSet;
        if (wr2) data2Q[i] <= csrWrData;
        else if (strobe.decCount[i]) data2Q[i] <= data2Q[i] - 1'b1;
        if (wr3) data3Q[i] <= csrWrData;
      end
    end
  end

  always_comb begin
    unique case (csrAddr)
      ADDR_SEL: csrRdData = XLEN'(selQ);
      ADDR_D1:  csrRdData = data1Q[selQ];
      ADDR_D2:  csrRdData = data2Q[selQ];
      ADDR_D3:  csrRdData = data3Q[selQ];
      default:  csrRdData = '0;
    endcase
  end
endmodule

// File: rtl/dtrig_match.sv
module dtrig_match
  import dtrig_pkg::*;
#(
  parameter int NUM_TRIG = 4,
  localparam int CNT_W = $clog2(NUM_TRIG + 1)
) (
  input  logic                          evValid,
  input  logic [2:0]                    evKind,
  input  logic [XLEN-1:0]               evValue,
  input  logic                          evTiming,
  input  logic [1:0]                    privMode,
  input  logic                          retireValid,
  input  logic                          cfgLoadDataEn,
  input  logic                          cfgOpcodeEn,
  input  logic                          cfgEvenOddChain,
  input  logic [NUM_TRIG-1:0][XLEN-1:0] data1Q,
  input  logic [NUM_TRIG-1:0][XLEN-1:0] data2Q,
  input  logic [NUM_TRIG-1:0]           wroteNow,
  output trig_strobe_t                  strobe,
  output logic [CNT_W-1:0]              tripBefore,
  output logic [CNT_W-1:0]              tripAfter,
  output logic                          enterDebug
);
  logic [NUM_TRIG-1:0] hitNow, link, okUp, okDown, fired, cntFire, cntZero;

  for (genvar i = 0; i < NUM_TRIG; i++) begin : g_cmp
    logic isMatch, isCount, modeOk, kindOk, dataSel;
    logic [XLEN-1:0] c1;
    assign c1      = data1Q[i];
    assign isMatch = c1[31:28] == TYPE_MATCH;
    assign isCount = c1[31:28] == TYPE_COUNT;
    assign dataSel = c1[B_DATA];

    always_comb begin
      unique case (privMode)
        2'd0:    modeOk = c1[B_UEN];
        2'd1:    modeOk = c1[B_SEN];
        2'd3:    modeOk = c1[B_MEN];
        default: modeOk = 1'b0;
      endcase
    end

    always_comb begin
      unique case (evKind)
        EV_LD_ADDR: kindOk = c1[B_LOAD]  && !dataSel;
        EV_ST_ADDR: kindOk = c1[B_STORE] && !dataSel;
        EV_LD_DATA: kindOk = c1[B_LOAD]  &&  dataSel && cfgLoadDataEn;
        EV_ST_DATA: kindOk = c1[B_STORE] &&  dataSel;
        EV_FETCH:   kindOk = c1[B_EXEC]  && !dataSel;
        EV_OPCODE:  kindOk = c1[B_EXEC]  &&  dataSel && cfgOpcodeEn;
        default:    kindOk = 1'b0;
      endcase
    end

    assign hitNow[i] = evValid && isMatch && modeOk && kindOk &&
                       (c1[B_AFTER] == evTiming) && (evValue == data2Q[i]);
    assign link[i]   = isMatch && c1[B_LINK] && (i < NUM_TRIG - 1) &&
                       (!cfgEvenOddChain || (i % 2 == 0));
    assign cntFire[i] = retireValid && isCount && modeOk &&
                        (data2Q[i] != '0) && !wroteNow[i];
    assign cntZero[i] = cntFire[i] && (data2Q[i] == XLEN'(1));
  end

  // A chain fires when every member from its start up to here and from
  // here down to its end has matched.
  always_comb begin
    for (int i = 0; i < NUM_TRIG; i++) begin
      if (i > 0 && link[i-1]) okUp[i] = hitNow[i] & okUp[i-1];
      else                    okUp[i] = hitNow[i];
    end
    for (int i = NUM_TRIG - 1; i >= 0; i--) begin
      if (i < NUM_TRIG - 1 && link[i]) okDown[i] = hitNow[i] & okDown[i+1];
      else                             okDown[i] = hitNow[i];
    end
    fired = okUp & okDown;
  end

  always_comb begin
    strobe     = '0;
    tripBefore = '0;
    tripAfter  = '0;
    enterDebug = 1'b0;
    for (int i = 0; i < NUM_TRIG; i++) begin
      strobe.setLocal[i] = hitNow[i] | cntZero[i];
      strobe.setHit[i]   = fired[i] | cntZero[i];
      strobe.decCount[i] = cntFire[i];
      if (fired[i] && !data1Q[i][B_AFTER]) tripBefore = tripBefore + CNT_W'(1);
      if ((fired[i] && data1Q[i][B_AFTER]) || cntZero[i])
        tripAfter = tripAfter + CNT_W'(1);
      if ((fired[i] || cntZero[i]) && data1Q[i][15:12] == ACT_DEBUG)
        enterDebug = 1'b1;
    end
  end
endmodule

// File: rtl/dtrig_unit.sv
module dtrig_unit
  import dtrig_pkg::*;
#(
  parameter int NUM_TRIG = 4,
  localparam int CNT_W = $clog2(NUM_TRIG + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             csrWrEn,
  input  logic [11:0]      csrAddr,
  input  logic [31:0]      csrWrData,
  output logic [31:0]      csrRdData,
  input  logic             evValid,
  input  logic [2:0]       evKind,
  input  logic [31:0]      evValue,
  input  logic             evTiming,
  input  logic [1:0]       privMode,
  input  logic             retireValid,
  input  logic             cfgLoadDataEn,
  input  logic             cfgOpcodeEn,
  input  logic             cfgEvenOddChain,
  output logic [CNT_W-1:0] tripBefore,
  output logic [CNT_W-1:0] tripAfter,
  output logic             enterDebug
);
  trig_strobe_t strobe;
  logic [NUM_TRIG-1:0][XLEN-1:0] data1Q, data2Q;
  logic [NUM_TRIG-1:0] wroteNow;

  dtrig_regs #(.NUM_TRIG(NUM_TRIG)) u_regs (
    .clk(clk), .rstN(rstN), .csrWrEn(csrWrEn), .csrAddr(csrAddr),
    .csrWrData(csrWrData), .csrRdData(csrRdData), .strobe(strobe),
    .data1Q(data1Q), .data2Q(data2Q), .wroteNow(wroteNow)
  );

  dtrig_match #(.NUM_TRIG(NUM_TRIG)) u_match (
    .evValid(evValid), .evKind(evKind), .evValue(evValue),
    .evTiming(evTiming), .privMode(privMode), .retireValid(retireValid),
    .cfgLoadDataEn(cfgLoadDataEn), .cfgOpcodeEn(cfgOpcodeEn),
    .cfgEvenOddChain(cfgEvenOddChain), .data1Q(data1Q), .data2Q(data2Q),
    .wroteNow(wroteNow), .strobe(strobe), .tripBefore(tripBefore),
    .tripAfter(tripAfter), .enterDebug(enterDebug)
  );
endmodule

// File: rtl/dtrig_unit_chk.sv
module dtrig_unit_chk #(
  parameter int NUM_TRIG = 4,
  localparam int CNT_W = $clog2(NUM_TRIG + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic [11:0]      csrAddr,
  input logic [31:0]      csrRdData,
  input logic             evValid,
  input logic [2:0]       evKind,
  input logic             evTiming,
  input logic             retireValid,
  input logic             cfgLoadDataEn,
  input logic [CNT_W-1:0] tripBefore,
  input logic [CNT_W-1:0] tripAfter,
  input logic             enterDebug
);
  p_quiet_idle_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!evValid && !retireValid) |-> (tripBefore == '0 && tripAfter == '0 && !enterDebug));

  p_after_slot_r4: assert property (@(posedge clk) disable iff (!rstN)
    (evValid && evTiming) |-> (tripBefore == '0));

  p_before_slot_r4: assert property (@(posedge clk) disable iff (!rstN)
    (evValid && !evTiming && !retireValid) |-> (tripAfter == '0));

  p_count_bound_r6: assert property (@(posedge clk) disable iff (!rstN)
    (int'(tripBefore) + int'(tripAfter)) <= NUM_TRIG);

  p_debug_needs_trip_r11: assert property (@(posedge clk) disable iff (!rstN)
    enterDebug |-> (tripBefore != '0 || tripAfter != '0));

  p_select_range_r2: assert property (@(posedge clk) disable iff (!rstN)
    (csrAddr == 12'h7A0) |-> (csrRdData < NUM_TRIG));

  p_ld_data_gate_r8: assert property (@(posedge clk) disable iff (!rstN)
    (evValid && evKind == 3'd2 && !cfgLoadDataEn && !retireValid)
      |-> (tripBefore == '0 && tripAfter == '0));
endmodule

bind dtrig_unit dtrig_unit_chk #(.NUM_TRIG(NUM_TRIG)) u_chk (
  .clk(clk), .rstN(rstN), .csrAddr(csrAddr), .csrRdData(csrRdData),
  .evValid(evValid), .evKind(evKind), .evTiming(evTiming),
  .retireValid(retireValid), .cfgLoadDataEn(cfgLoadDataEn),
  .tripBefore(tripBefore), .tripAfter(tripAfter), .enterDebug(enterDebug)
);

// File: tb/sim_dtrig_unit.sv
`timescale 1ns/1ps
module sim_dtrig_unit;
  localparam int NT = 4;
  localparam int CW = $clog2(NT + 1);
  localparam logic [31:0] MODES = 32'h58;
  localparam logic [31:0] A = 32'h1000, B = 32'h2000, C = 32'h3000;

  logic clk = 1'b0, rstN = 1'b0;
  logic csrWrEn = 0; logic [11:0] csrAddr = '0; logic [31:0] csrWrData = '0;
  logic [31:0] csrRdData;
  logic evValid = 0; logic [2:0] evKind = '0; logic [31:0] evValue = '0;
  logic evTiming = 0; logic [1:0] privMode = 2'd3; logic retireValid = 0;
  logic cfgLoadDataEn = 0, cfgOpcodeEn = 0, cfgEvenOddChain = 0;
  logic [CW-1:0] tripBefore, tripAfter;
  logic enterDebug;

  int nChecks = 0, nFail = 0;
  logic [31:0] sh1 [NT];
  logic [31:0] sh2 [NT];

  always #4 clk = ~clk;

  dtrig_unit #(.NUM_TRIG(NT)) u0 (.*);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    csrWrEn = 0; evValid = 0; retireValid = 0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); idle(); csrWrEn = 1; csrAddr = a; csrWrData = d;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); idle(); csrAddr = a; #1 d = csrRdData;
  endtask

  task automatic prog(input int i, input logic [31:0] d1, input logic [31:0] d2);
    wr(12'h7A0, i); wr(12'h7A1, d1); wr(12'h7A2, d2);
    sh1[i] = d1; sh2[i] = d2;
  endtask

  task automatic clearAll();
    for (int i = 0; i < NT; i++) prog(i, 32'h0, 32'h0);
  endtask

  task automatic ev(input int k, input logic [31:0] v, input bit t, input logic [1:0] p,
                    output int nb, output int na, output bit dbg);
    @(negedge clk); idle(); evValid = 1; evKind = 3'(k); evValue = v; evTiming = t; privMode = p;
    #1 nb = int'(tripBefore); na = int'(tripAfter); dbg = enterDebug;
  endtask

  task automatic retire(input bit alsoWr3, output int na, output bit dbg);
    @(negedge clk); idle(); retireValid = 1;
    if (alsoWr3) begin csrWrEn = 1; csrAddr = 12'h7A3; csrWrData = 32'h55; end
    #1 na = int'(tripAfter); dbg = enterDebug;
  endtask

  // kind: 0 ld addr,1 st addr,2 ld data,3 st data,4 fetch,5 opcode
  function automatic logic [31:0] mk(input int kind, input bit after, input bit chainB,
                                     input logic [3:0] act, input logic [31:0] modes);
    logic [31:0] w;
    w = {4'd2, 28'h0} | modes;
    case (kind)
      0: w[0] = 1; 1: w[1] = 1; 2: begin w[0] = 1; w[19] = 1; end
      3: begin w[1] = 1; w[19] = 1; end 4: w[2] = 1;
      default: begin w[2] = 1; w[19] = 1; end
    endcase
    w[18] = after; w[11] = chainB; w[15:12] = act;
    return w;
  endfunction

  function automatic bit bMatch(input int i, input int k, input logic [31:0] v,
                                input bit t, input logic [1:0] p);
    logic [31:0] w; bit mOk, kOk;
    w = sh1[i];
    if (w[31:28] != 4'd2) return 0;
    mOk = (p == 0) ? w[3] : (p == 1) ? w[4] : (p == 3) ? w[6] : 1'b0;
    case (k)
      0: kOk = w[0] && !w[19]; 1: kOk = w[1] && !w[19];
      2: kOk = w[0] && w[19] && cfgLoadDataEn; 3: kOk = w[1] && w[19];
      4: kOk = w[2] && !w[19]; 5: kOk = w[2] && w[19] && cfgOpcodeEn;
      default: kOk = 0;
    endcase
    return mOk && kOk && (w[18] == t) && (v == sh2[i]);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    nFail++; nChecks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    logic [31:0] r; int nb, na; bit dbg;
    void'($urandom(32'd12345));
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1;

    // R1 reset state
    rd(12'h7A0, r); check("R1 select", r, 0);
    for (int i = 0; i < NT; i++) begin
      wr(12'h7A0, i);
      rd(12'h7A1, r); check("R1 data1", r, 0);
      rd(12'h7A2, r); check("R1 data2", r, 0);
      rd(12'h7A3, r); check("R1 data3", r, 0);
    end
    @(negedge clk); idle(); #1 check("R1 idle counts", {tripBefore, tripAfter, enterDebug}, 0);

    // R2 select range and unmapped read
    wr(12'h7A0, 2); rd(12'h7A0, r); check("R2 select write", r, 2);
    wr(12'h7A0, 7); rd(12'h7A0, r); check("R2 select out of range ignored", r, 2);
    wr(12'h7A3, 32'hABCD); wr(12'h7A0, 1); rd(12'h7A3, r); check("R2 data3 per trigger", r, 0);
    wr(12'h7A0, 2); rd(12'h7A3, r); check("R2 data3 readback", r, 32'hABCD);
    rd(12'h7A5, r); check("R2 unmapped reads zero", r, 0);

    // R3 R4 single before-timing match, R11 debug action
    clearAll();
    prog(0, mk(0, 0, 0, 4'd1, MODES), A);
    ev(0, A, 0, 2'd3, nb, na, dbg);
    check("R3 load addr match before", nb, 1); check("R4 after count zero", na, 0);
    check("R11 enter debug", dbg, 1);
    ev(1, A, 0, 2'd3, nb, na, dbg); check("R3 store kind does not match load trigger", nb, 0);
    ev(0, A, 1, 2'd3, nb, na, dbg); check("R3 timing mismatch", nb + na, 0);
    wr(12'h7A0, 0); rd(12'h7A1, r); check("R6 hit and local set", r[21:20], 2'b11);
    prog(1, mk(3, 1, 0, 4'd0, MODES), B);
    ev(3, B, 1, 2'd3, nb, na, dbg);
    check("R4 after count", na, 1); check("R11 no debug for action 0", dbg, 0);

    // R6 chain of two
    clearAll();
    prog(0, mk(0, 0, 1, 4'd0, MODES), A);
    prog(1, mk(0, 0, 0, 4'd0, MODES), A);
    ev(0, A, 0, 2'd3, nb, na, dbg); check("R6 chain fires both", nb, 2);
    wr(12'h7A0, 1); rd(12'h7A1, r); check("R6 member hit", r[21:20], 2'b11);
    // R5 partial chain: local only
    prog(0, mk(0, 0, 1, 4'd0, MODES), A);
    prog(1, mk(0, 0, 0, 4'd0, MODES), C);
    ev(0, A, 0, 2'd3, nb, na, dbg); check("R6 partial chain no trip", nb, 0);
    wr(12'h7A0, 0); rd(12'h7A1, r); check("R5 local without hit", r[21:20], 2'b10);

    // R7 even/odd restriction
    clearAll();
    prog(1, mk(0, 0, 1, 4'd0, MODES), A);
    prog(2, mk(0, 0, 0, 4'd0, MODES), C);
    cfgEvenOddChain = 0;
    ev(0, A, 0, 2'd3, nb, na, dbg); check("R7 odd link honoured when free", nb, 0);
    cfgEvenOddChain = 1;
    ev(0, A, 0, 2'd3, nb, na, dbg); check("R7 odd link ignored in pair mode", nb, 1);
    cfgEvenOddChain = 0;

    // R8 gating of load data and opcode
    clearAll();
    prog(0, mk(2, 0, 0, 4'd0, MODES), B);
    prog(1, mk(5, 1, 0, 4'd0, MODES), C);
    ev(2, B, 0, 2'd3, nb, na, dbg); check("R8 load data gated off", nb, 0);
    ev(5, C, 1, 2'd3, nb, na, dbg); check("R8 opcode gated off", na, 0);
    cfgLoadDataEn = 1; cfgOpcodeEn = 1;
    ev(2, B, 0, 2'd3, nb, na, dbg); check("R8 load data enabled", nb, 1);
    ev(5, C, 1, 2'd3, nb, na, dbg); check("R8 opcode enabled", na, 1);

    // R9 privilege enables
    clearAll();
    prog(0, mk(4, 0, 0, 4'd0, 32'h40), A);
    ev(4, A, 0, 2'd0, nb, na, dbg); check("R9 user blocked", nb, 0);
    ev(4, A, 0, 2'd1, nb, na, dbg); check("R9 supervisor blocked", nb, 0);
    ev(4, A, 0, 2'd3, nb, na, dbg); check("R9 machine allowed", nb, 1);

    // R10 instruction count
    clearAll();
    prog(3, {4'd3, 28'h0} | MODES | 32'h1000, 2);
    retire(0, na, dbg); check("R10 first retire no fire", na, 0);
    rd(12'h7A2, r); check("R10 decremented", r, 1);
    retire(0, na, dbg); check("R10 fires at zero", na, 1); check("R11 count debug", dbg, 1);
    rd(12'h7A2, r); check("R10 reached zero", r, 0);
    rd(12'h7A1, r); check("R10 hit bits", r[21:20], 2'b11);
    retire(0, na, dbg); check("R10 zero stays quiet", na, 0);
    wr(12'h7A2, 3);
    retire(1, na, dbg);
    rd(12'h7A2, r); check("R10 skip when written", r, 3);
    retire(0, na, dbg); rd(12'h7A2, r); check("R10 resumes", r, 2);

    // R3 R4 random independent triggers
    for (int it = 0; it < 200; it++) begin
      if (it % 25 == 0) begin
        for (int i = 0; i < NT; i++)
          prog(i, mk(int'($urandom_range(5)), 1'($urandom_range(1)), 0, 4'd0, MODES),
               32'h100 * (1 + $urandom_range(2)));
      end
      begin
        int k; logic [31:0] v; bit t; logic [1:0] p; int eb, ea;
        k = int'($urandom_range(5)); v = 32'h100 * (1 + $urandom_range(2));
        t = 1'($urandom_range(1)); p = ($urandom_range(2) == 2) ? 2'd3 : 2'($urandom_range(1));
        eb = 0; ea = 0;
        for (int i = 0; i < NT; i++)
          if (bMatch(i, k, v, t, p)) begin if (sh1[i][18]) ea++; else eb++; end
        ev(k, v, t, p, nb, na, dbg);
        check("R3 random before count", nb, eb);
        check("R4 random after count", na, ea);
      end
    end

    @(negedge clk); idle();
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule